// File: doc/BRIEF.md
# Hierarchical Priority Encoder (64 requests)

This block ranks up to 64 request lines, which are active low, and reports the index of the highest-numbered line that is requesting. It also gives an active-high valid flag and an active-high idle flag. The logic is purely combinational. There are no registers, so the result follows the inputs within the same cycle.

Internally the requests are split into groups of eight. Each group is handled by an 8-input ranking slice. Each slice has three active-low signals: an enable input, an enable output and a group-select output. The slices form a chain from the top group down, and a slice is enabled only when every group above it has no request. As a result, at most one slice can claim a request. A second-level encoder ranks the group-select outputs to form the upper address bits. The lower three bits are the OR of the slice addresses. A parameter selects eight groups (64 inputs) or two groups (16 inputs). With two groups, the group-select of the high slice alone supplies address bit 3.

A global active-low enable masks the whole tree. While it is negated, the block reports no request.

Top module: `prio_enc_tree`

## Requirements
- R1: When `en_n` is 0 and at least one bit of `req_n` is 0, `valid` is 1, `idle` is 0, and `addr` equals the largest index i with `req_n[i]` = 0.
- R2: Within one group of eight lines, the higher line number wins. For example, lines 5 and 2 of group 0 requesting together gives `addr` = 5.
- R3: A request in a higher group beats any request in a lower group. A lower group is consulted only when all higher groups are free.
- R4: When no bit of `req_n` is 0, `valid` is 0, `idle` is 1 and `addr` is all zeros.
- R5: When `en_n` is 1, `valid` is 0, `idle` is 1 and `addr` is all zeros, whatever `req_n` holds.
- R6: At most one group slice asserts its group-select at any time. The enable leaving the lowest slice is asserted exactly when the block is enabled and idle.
- R7: `addr[AW-1:3]` is the number of the winning group and `addr[2:0]` is the winning line's position inside that group (line = 8·group + position).
- R8: With `GROUPS` = 2 the block takes 16 requests and has a 4-bit `addr`. Bit 3 is 1 exactly when a line from 8 to 15 wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | GROUPS*8 | Request lines, active low; bit i is line i |
| en_n | input | 1 | Global enable, active low |
| addr | output | $clog2(GROUPS)+3 | Index of the winning line, active high |
| valid | output | 1 | High when some enabled request is present |
| idle | output | 1 | High when no enabled request is present |

## Verification
The bench drives a single asserted line at every position, one position at a time. This shows that each line maps to its own index and that every group feeds the correct upper bits. Pairs of lines are then asserted, both inside one group and across two groups, to separate ranking within a slice from ranking through the enable chain. The all-free, all-requesting and disabled-with-requests patterns cover the idle and masking cases. Random vectors at several densities, including very sparse ones, catch cross-group errors, and both the 64-line and the 16-line configurations are compared against a top-down scan.

// File: rtl/prio_enc_tree.sv
module prio_enc_tree #(
  parameter int GROUPS = 8,
  localparam int N  = GROUPS * 8,
  localparam int GW = $clog2(GROUPS),
  localparam int AW = GW + 3
) (
  input  logic [N-1:0]  req_n,
  input  logic          en_n,
  output logic [AW-1:0] addr,
  output logic          valid,
  output logic          idle
);

  function automatic logic [2:0] top_idx(input logic [7:0] act);
    top_idx = '0;
    for (int i = 0; i < 8; i++)
      if (act[i]) top_idx = i[2:0];
  endfunction

  logic [GROUPS:0]      chain_n;
  logic [GROUPS-1:0]    gs_n;
  logic [2:0]           a_n [GROUPS];
  logic [2:0]           lo;
  logic [GW-1:0]        hi;

  assign chain_n[GROUPS] = en_n;

  for (genvar g = 0; g < GROUPS; g++) begin : g_slice
    logic [7:0] act;
    logic       on, hit;
    assign act        = ~req_n[g*8 +: 8];
    assign on         = ~chain_n[g+1];
    assign hit        = |act;
    assign gs_n[g]    = ~(on & hit);
    assign chain_n[g] = ~(on & ~hit);
    assign a_n[g]     = (on && hit) ? ~top_idx(act) : 3'b111;
  end

  always_comb begin
    lo = '0;
    for (int g = 0; g < GROUPS; g++) lo |= ~a_n[g];
  end

  if (GROUPS == 2) begin : g_two
    assign hi = ~gs_n[1];
  end else begin : g_rank
    logic [7:0] grp_act;
    logic [2:0] grp_idx;
    always_comb begin
      grp_act = '0;
      grp_act[GROUPS-1:0] = ~gs_n;
      grp_idx = (!en_n && |grp_act) ? top_idx(grp_act) : 3'b000;
    end
    assign hi = grp_idx[GW-1:0];
  end

  assign valid = ~(&gs_n);
  assign idle  = ~valid;
  assign addr  = {hi, lo};

  always_comb begin
    AST_ONE_SLICE: assert ($onehot0(~gs_n)) else $error("several slices active"); // R6
    AST_CHAIN_END: assert ((chain_n[0] == 1'b0) == (!en_n && (&req_n))) else $error("chain end wrong"); // R6
    AST_IDLE_ZERO: assert (!idle || addr == '0) else $error("idle with nonzero addr"); // R4
    AST_MASKED: assert (!en_n || !valid) else $error("valid while disabled"); // R5
    AST_HIT_BIT: assert (!valid || !req_n[addr]) else $error("addr names a free line"); // R1
    AST_NONE_ABOVE: assert (!valid || (((~req_n) >> addr) == {{(N-1){1'b0}}, 1'b1})) else $error("higher line ignored"); // R3
  end

endmodule

// File: tb/sim_prio_enc_tree.sv
module sim_prio_enc_tree;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] req_n = '1;
  logic [15:0] req16_n = '1;
  logic        en_n = 1'b0;
  logic [5:0]  addr;
  logic [3:0]  addr16;
  logic        valid, idle, valid16, idle16;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  prio_enc_tree #(.GROUPS(8)) u0 (.req_n(req_n), .en_n(en_n), .addr(addr), .valid(valid), .idle(idle));
  prio_enc_tree #(.GROUPS(2)) u1 (.req_n(req16_n), .en_n(en_n), .addr(addr16), .valid(valid16), .idle(idle16));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] v, input logic [15:0] v16, input logic en, input string tag);
    int e64, e16;
    @(posedge clk);
    req_n = v; req16_n = v16; en_n = en;
    @(negedge clk);
    e64 = -1; e16 = -1;
    if (!en) begin
      for (int i = 63; i >= 0; i--) if (!v[i] && e64 < 0) e64 = i;
      for (int i = 15; i >= 0; i--) if (!v16[i] && e16 < 0) e16 = i;
    end
    check({tag, " valid"}, valid, e64 >= 0);
    check({tag, " idle"}, idle, e64 < 0);
    check({tag, " addr"}, addr, e64 >= 0 ? e64 : 0);
    check({tag, " R8 valid16"}, valid16, e16 >= 0);
    check({tag, " R8 addr16"}, addr16, e16 >= 0 ? e16 : 0);
    check({tag, " R8 bit3"}, addr16[3], e16 >= 8);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [63:0] v;
    logic [15:0] w;
    @(negedge clk);
    check("R4 reset valid", valid, 0);
    check("R4 reset idle", idle, 1);
    check("R4 reset addr", addr, 0);
    apply('1, '1, 1'b0, "R4 none");
    apply('0, '0, 1'b0, "R1 all");
    for (int i = 0; i < 64; i++) begin
      v = '1; v[i] = 1'b0;
      w = '1; w[i % 16] = 1'b0;
      apply(v, w, 1'b0, "R7 single");
    end
    for (int g = 0; g < 8; g++)
      for (int p = 1; p < 8; p++) begin
        v = '1; v[g*8 + p] = 1'b0; v[g*8] = 1'b0; v[g*8 + p - 1] = 1'b0;
        w = '1; w[(g%2)*8 + p] = 1'b0; w[(g%2)*8] = 1'b0;
        apply(v, w, 1'b0, "R2 in-group");
      end
    for (int hg = 1; hg < 8; hg++)
      for (int lg = 0; lg < hg; lg++) begin
        v = '1; v[hg*8] = 1'b0; v[lg*8 + 7] = 1'b0;
        w = '1; w[8] = 1'b0; w[7] = 1'b0;
        apply(v, w, 1'b0, "R3 cross-group");
      end
    apply('0, '0, 1'b1, "R5 masked all");
    for (int k = 0; k < 20; k++) begin
      v = {$urandom, $urandom}; w = 16'($urandom);
      apply(v, w, 1'b1, "R5 masked rand");
    end
    for (int k = 0; k < 600; k++) begin
      v = {$urandom, $urandom}; w = 16'($urandom);
      if (k % 3 == 1) begin v = v | {$urandom, $urandom}; w = w | 16'($urandom); end
      if (k % 3 == 2) begin
        v = '1; v[$urandom % 64] = 1'b0; v[$urandom % 64] = 1'b0;
        w = '1; w[$urandom % 16] = 1'b0;
      end
      apply(v, w, 1'b0, "R1 random");
    end
    apply('1, '1, 1'b0, "R6 back idle");
    finish_up();
  end
endmodule